// File: doc/BRIEF.md
# Polarity/Phase Selectable SPI Master Shift Engine

This block is the serial engine of an SPI master. It moves one 8-bit byte out on MOSI while it takes one byte in from MISO, most significant bit first. A small register interface sets it up. Software picks the idle clock level, the clock phase and the interrupt enable, and sets a divider that gives the SCK half-period in system clocks. A write to the data register while the engine is idle starts a byte transfer. When the transfer ends, the received byte is in the data register and a completion flag is set. That flag can raise the single interrupt output.

The engine runs in both phase modes. With phase 1, it waits one half-period after the start and then gives the first SCK edge, which only puts the MSB on MOSI. Sampling then happens on the even edges. With phase 0, the MSB is on MOSI before any edge, and sampling happens on the odd edges. Each transfer has exactly sixteen SCK edges, and SCK then rests at its idle level. A write to the data register during a transfer is discarded and sets a sticky collision flag. That flag never causes an interrupt. Software clears both flags by reading the status register while the flag is set and then accessing the data register.

Top module: `spim_top`

## Requirements
- R1: After reset, the control, divider, status and data registers read 0, and sclk_o, mosi_o and irq_o are 0.
- R2: A data-register write (address 3) while idle starts a transfer. The transfer has exactly 16 SCK edges, each H system clocks after the previous one. The first edge comes H clocks after the write edge, and the last edge ends the transfer. H is the divider value, and 0 counts as 1.
- R3: With phase 1 (control bit 1 set), the first edge drives the transmit MSB onto MOSI. MISO is sampled on even edges and MOSI advances on odd edges, MSB first.
- R4: With phase 0, MOSI holds the transmit MSB before the first edge. MISO is sampled on odd edges and MOSI advances on even edges, MSB first.
- R5: When idle, SCK rests at the level of control bit 0, including after the 16th edge.
- R6: At the 16th edge, the data register takes the byte received from MISO and status bit 7 (completion) is set, never earlier.
- R7: irq_o is high exactly while status bit 7 is set and control bit 2 (interrupt enable) is set.
- R8: A data-register write during a transfer sets status bit 6 (collision), leaves the transfer in flight and its bytes unchanged, starts nothing, and never raises irq_o. The interrupt for the running transfer still arrives when it ends.
- R9: A status flag is cleared only by a status read (address 2) taken while it is set, followed by a data-register access. A data access with no such read leaves the flags set.
- R10: Register map: address 0 control (bit 0 idle level, bit 1 phase, bit 2 interrupt enable), address 1 divider, address 2 status, address 3 data. Control and divider read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench times every SCK edge against the divider, the phase-1 half-period lead-in included. A design that starts early or that miscounts the divider fails the spacing check. A slave model on the pins samples and drives on the edges the phase calls for, so a design that samples on the wrong parity of edge, or that launches the MSB late, returns a wrong byte. A collision write lands in the middle of a transfer. If that write corrupted the outgoing byte, started a second transfer or pulsed the interrupt, the bench reports it. Flag clearing is tried both with and without the preceding status read, which exposes a flag that is not sticky or that clears on the wrong access.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int DATA_W = 8;
    localparam int EDGES  = 2 * DATA_W;
    localparam int EDGE_W = $clog2(EDGES + 1);

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DIV  = 2'd1,
        REG_STAT = 2'd2,
        REG_DATA = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic irq_en;
        logic cpha;
        logic cpol;
    } ctrl_t;

    // Phase 1 samples on even-numbered edges, phase 0 on odd-numbered ones.
    function automatic logic samples_on(input logic cpha, input logic [EDGE_W-1:0] idx);
        return cpha ? ~idx[0] : idx[0];
    endfunction

endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_per,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // A divider value of zero behaves as one system clock per half-period.
    assign lim  = (half_per == '0) ? '0 : half_per - DIV_W'(1);
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  ctrl_t             cfg,
    input  logic              tick,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              busy,
    output logic              done_evt,
    output logic [DATA_W-1:0] rx_byte,
    output logic [EDGE_W-1:0] edge_cnt
);
    ctrl_t             mode_q;
    logic [DATA_W-1:0] shreg;
    logic              latch;
    logic [EDGE_W-1:0] nxt;

    assign nxt      = edge_cnt + EDGE_W'(1);
    assign done_evt = busy && tick && (nxt == EDGE_W'(EDGES));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            shreg    <= '0;
            latch    <= 1'b0;
            edge_cnt <= '0;
            busy     <= 1'b0;
            sck      <= 1'b0;
            mosi     <= 1'b0;
            rx_byte  <= '0;
        end else if (!busy) begin
            sck <= cfg.cpol;
            if (start) begin
                busy     <= 1'b1;
                mode_q   <= cfg;
                edge_cnt <= '0;
                shreg    <= tx_byte;
                if (!cfg.cpha) begin
                    mosi <= tx_byte[DATA_W-1];
                end
            end
        end else if (tick) begin
            edge_cnt <= nxt;
            sck      <= ~sck;
            if (samples_on(mode_q.cpha, nxt)) begin
                latch <= miso;
            end
            if (mode_q.cpha && nxt == EDGE_W'(1)) begin
                mosi <= shreg[DATA_W-1];
            end else if (done_evt) begin
                busy    <= 1'b0;
                rx_byte <= {shreg[DATA_W-2:0], mode_q.cpha ? miso : latch};
            end else if (!samples_on(mode_q.cpha, nxt)) begin
                shreg <= {shreg[DATA_W-2:0], latch};
                mosi  <= shreg[DATA_W-2];
            end
        end
    end
endmodule

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              busy,
    input  logic              done_evt,
    input  logic [DATA_W-1:0] rx_byte,
    output ctrl_t             cfg,
    output logic [DIV_W-1:0]  half_per,
    output logic              start,
    output logic              done_flag,
    output logic              col_flag,
    output logic [DATA_W-1:0] rdata
);
    reg_addr_e addr;
    logic      wr_data, rd_stat, acc_data, collide;
    logic      arm_done, arm_col;

    assign addr     = reg_addr_e'(bus_addr);
    assign wr_data  = bus_sel && bus_wr && addr == REG_DATA;
    assign rd_stat  = bus_sel && !bus_wr && addr == REG_STAT;
    assign acc_data = bus_sel && addr == REG_DATA;
    assign start    = wr_data && !busy;
    assign collide  = wr_data && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            half_per  <= '0;
            arm_done  <= 1'b0;
            arm_col   <= 1'b0;
            done_flag <= 1'b0;
            col_flag  <= 1'b0;
        end else begin
            if (bus_sel && bus_wr && addr == REG_CTRL) begin
                cfg <= ctrl_t'(bus_wdata[2:0]);
            end
            if (bus_sel && bus_wr && addr == REG_DIV) begin
                half_per <= bus_wdata[DIV_W-1:0];
            end
            if (rd_stat) begin
                arm_done <= done_flag;
                arm_col  <= col_flag;
            end else if (acc_data) begin
                arm_done <= 1'b0;
                arm_col  <= 1'b0;
            end
            // A new event wins over a clear in the same cycle.
            if (done_evt) begin
                done_flag <= 1'b1;
            end else if (acc_data && arm_done) begin
                done_flag <= 1'b0;
            end
            if (collide) begin
                col_flag <= 1'b1;
            end else if (acc_data && arm_col) begin
                col_flag <= 1'b0;
            end
        end
    end

    always_comb begin
        case (addr)
            REG_CTRL: rdata = {5'b0, cfg};
            REG_DIV:  rdata = DATA_W'(half_per);
            REG_STAT: rdata = {done_flag, col_flag, 6'b0};
            default:  rdata = rx_byte;
        endcase
    end
endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       sclk_o,
    output logic       mosi_o,
    input  logic       miso_i,
    output logic       irq_o
);
    ctrl_t             cfg;
    logic [DIV_W-1:0]  half_per;
    logic              start, busy, tick, done_evt;
    logic              done_flag, col_flag;
    logic [DATA_W-1:0] rx_byte;
    logic [EDGE_W-1:0] edge_cnt;

    spim_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .busy(busy), .done_evt(done_evt), .rx_byte(rx_byte),
        .cfg(cfg), .half_per(half_per), .start(start),
        .done_flag(done_flag), .col_flag(col_flag), .rdata(bus_rdata)
    );

    spim_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst(rst), .run(busy), .half_per(half_per), .tick(tick)
    );

    spim_shifter u_shift (
        .clk(clk), .rst(rst), .start(start), .tx_byte(bus_wdata), .cfg(cfg),
        .tick(tick), .miso(miso_i), .sck(sclk_o), .mosi(mosi_o), .busy(busy),
        .done_evt(done_evt), .rx_byte(rx_byte), .edge_cnt(edge_cnt)
    );

    assign irq_o = done_flag && cfg.irq_en;
endmodule

// File: rtl/spim_checker.sv
module spim_checker
    import spim_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              tick,
    input logic              sck,
    input logic              cpol,
    input logic              done_flag,
    input logic              col_flag,
    input logic              irq,
    input logic [EDGE_W-1:0] edge_cnt
);
    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy) && $stable(cpol)) |-> (sck == cpol)); // R5

    AST_SCK_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sck) && $past(busy)) |-> $past(tick)); // R2

    AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (rst)
        edge_cnt <= EDGE_W'(EDGES)); // R2

    AST_DONE_FROM_XFER: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> $past(busy)); // R6

    AST_COLLIDE_IN_XFER: assert property (@(posedge clk) disable iff (rst)
        $rose(col_flag) |-> $past(busy)); // R8

    AST_COLLIDE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        ($rose(col_flag) && !done_flag) |-> !irq); // R8
endmodule

bind spim_top spim_checker u_chk (
    .clk(clk), .rst(rst), .busy(busy), .tick(tick), .sck(sclk_o),
    .cpol(cfg.cpol), .done_flag(done_flag), .col_flag(col_flag),
    .irq(irq_o), .edge_cnt(edge_cnt)
);

// File: tb/spim_top_bench.sv
`timescale 1ns/1ps
module spim_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sclk, mosi, irq;
    logic       miso = 1'b0;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, start_cyc = 0, last_cyc = 0, exp_h = 1, edge_n = 0;
    bit active = 0, pre_done = 0, cur_cpha = 0, cur_cpol = 0;
    logic [7:0] sl_tx = 8'd0, sl_rx = 8'd0;
    logic [7:0] exp_q[$];
    logic prev_sck = 1'b0;

    spim_top u_spim_top (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_o(sclk), .mosi_o(mosi),
        .miso_i(miso), .irq_o(irq)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    // Slave model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst && active) begin
            if (edge_n == 0 && !pre_done) begin
                pre_done = 1;
                if (!cur_cpha) begin
                    miso = sl_tx[7];
                    sl_tx = sl_tx << 1;
                end
            end
            if (sclk !== prev_sck) begin
                edge_n++;
                chk(cyc - last_cyc == exp_h, "R2 edge spacing", cyc - last_cyc, exp_h);
                last_cyc = cyc;
                if (cur_cpha ? (edge_n % 2 == 0) : (edge_n % 2 == 1)) begin
                    sl_rx = {sl_rx[6:0], mosi};
                end else if (edge_n < 16) begin
                    miso = sl_tx[7];
                    sl_tx = sl_tx << 1;
                end
                if (edge_n == 16) begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(sl_rx == e, cur_cpha ? "R3 mosi byte" : "R4 mosi byte", sl_rx, e);
                    chk(sclk == cur_cpol, "R5 idle after 16th edge", sclk, cur_cpol);
                    active = 0;
                    edge_n = 0;
                end
            end
        end
        prev_sck = sclk;
    end

    task automatic start_xfer(input bit pol, input bit pha, input bit ien,
                              input logic [7:0] dv, input logic [7:0] tx, input logic [7:0] sl);
        bus_write(2'd0, {5'b0, ien, pha, pol});
        bus_write(2'd1, dv);
        cur_cpol = pol; cur_cpha = pha;
        exp_h = (dv == 0) ? 1 : int'(dv);
        sl_tx = sl; sl_rx = 0; edge_n = 0; pre_done = 0;
        exp_q.push_back(tx);
        active = 1;
        bus_write(2'd3, tx);
        start_cyc = cyc;
        last_cyc = cyc;
    endtask

    task automatic finish_xfer(input bit ien, input logic [7:0] sl, input bit col);
        logic [7:0] v;
        while (cyc < start_cyc + 16 * exp_h - 1) @(negedge clk);
        chk(irq == 0, "R6 no early completion", irq, 0);
        @(negedge clk);
        chk(irq == ien, "R7 irq on completion", irq, ien);
        bus_read(2'd3, v);
        chk(v == sl, "R6 received byte", v, sl);
        bus_read(2'd2, v);
        chk(v == {1'b1, col, 6'b0}, "R9 sticky without status read", v, {1'b1, col, 6'b0});
        bus_read(2'd3, v);
        bus_read(2'd2, v);
        chk(v == 8'h00, "R9 cleared after sequence", v, 0);
        chk(irq == 0, "R7 irq drops with flag", irq, 0);
    endtask

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(sclk == 0 && mosi == 0 && irq == 0, "R1 pins after reset", {sclk, mosi, irq}, 0);
        for (int a = 0; a < 4; a++) begin
            bus_read(2'(a), v);
            chk(v == 0, "R1 register reset", v, 0);
        end
        bus_write(2'd0, 8'h07);
        bus_read(2'd0, v);
        chk(v == 8'h07, "R10 control readback", v, 8'h07);
        bus_write(2'd1, 8'h05);
        bus_read(2'd1, v);
        chk(v == 8'h05, "R10 divider readback", v, 8'h05);
        repeat (2) @(negedge clk);
        chk(sclk == 1, "R5 idle follows control", sclk, 1);

        start_xfer(0, 0, 1, 8'd2, 8'hA5, 8'h3C); finish_xfer(1, 8'h3C, 0);
        start_xfer(0, 1, 1, 8'd3, 8'h5A, 8'hC3); finish_xfer(1, 8'hC3, 0);
        start_xfer(1, 1, 0, 8'd1, 8'h81, 8'h7E); finish_xfer(0, 8'h7E, 0);
        start_xfer(1, 0, 1, 8'd0, 8'h0F, 8'hF0); finish_xfer(1, 8'hF0, 0);

        // R8: collision in the middle of a phase-1 transfer
        start_xfer(0, 1, 1, 8'd4, 8'h96, 8'h69);
        repeat (10) @(negedge clk);
        bus_write(2'd3, 8'hFF);
        @(negedge clk);
        chk(irq == 0, "R8 collision raises no irq", irq, 0);
        finish_xfer(1, 8'h69, 1);
        repeat (40) @(negedge clk);
        chk(sclk == 0 && active == 0, "R8 no second transfer", sclk, 0);
        chk(exp_q.size() == 0, "R2 every transfer completed", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule